// File: doc/BRIEF.md
# Double-Buffered PWM Counter Slice

This block is one PWM slice. A free-running counter is compared against a compare value to produce one pulse-width-modulated output. The period is set by a wrap value. Software writes the wrap and compare values into shadow registers at any time. The slice moves them into working registers only at the period boundary, so each period runs entirely on one consistent pair of values. Without the shadow copies, a write could land mid-period and produce a runt pulse or an overlong period.

The slice runs in two modes. In up-count mode the counter rises from zero to the wrap value and returns to zero. In phase-correct mode it rises to the wrap value, turns, and falls back to zero, which gives a centre-aligned output. In that mode the period boundary is the turnaround at the bottom, where the counter holds zero for two counts. Every boundary sets a sticky interrupt flag that software clears. An external count-enable input gates counting, so a fractional divider outside the slice can set the count rate. A synchronous enable input freezes the whole slice. The reset input is assumed to be already released synchronously by the clock domain's reset logic.

Top module: `pwm_slice`

## Requirements
- R1: In up-count mode (phase_correct = 0) the counter steps 0, 1, ..., TOP and then returns to 0, so one period is TOP + 1 counting cycles.
- R2: In phase-correct mode (phase_correct = 1) the counter steps 0, 1, ..., TOP, holds TOP for one more count, steps down to 0, and holds 0 for one more count, so one period is 2 × (TOP + 1) counting cycles.
- R3: The working wrap and compare values are loaded from the shadow registers only at the period boundary. In up-count mode this is the step from TOP to 0; in phase-correct mode it is the step from 0 to 0 at the bottom turnaround. Any number of shadow writes during a period leave that period unchanged, and the last value written before the boundary governs the next period.
- R4: pwm_out is high exactly while the counter is below the working compare value. A compare value of 0 keeps the output low; a compare value above TOP keeps it high.
- R5: Each period boundary sets irq. irq stays set, across further boundaries, until irq_clr is pulsed; after a clear it stays low until the next boundary.
- R6: The counter, and with it the direction and the boundary, advances only on clock cycles where cnt_en is high.
- R7: With en low the count, pwm_out, the working values and irq (apart from clearing) hold; shadow writes are still accepted and take effect at the first boundary after en returns high.
- R8: Reset clears the counter to 0, sets the direction to up, clears both shadow and both working values, and clears irq, so pwm_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous slice enable; low freezes the slice |
| cnt_en | input | 1 | Count-enable pulse from an external rate divider |
| phase_correct | input | 1 | 0 = up-count mode, 1 = up/down phase-correct mode |
| top_wr | input | 1 | Write strobe for the wrap-value shadow register |
| top_wdata | input | W | Wrap value written to the shadow register |
| cc_wr | input | 1 | Write strobe for the compare-value shadow register |
| cc_wdata | input | W | Compare value written to the shadow register |
| irq_clr | input | 1 | Clears the boundary interrupt flag |
| count | output | W | Current counter value |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Sticky boundary interrupt flag |

## Verification
The main function is run in up-count mode with count-enable held high, and in phase-correct mode with count-enable driven by a pseudo-random pattern. The continuous pattern checks that the count and output sequence matches the period length exactly. The random gating shows that only enabled cycles move the count. Each new period is preceded by a throwaway write and then the intended write in the closing cycles of the old period. A load taken mid-period therefore shows up as a wrong count or output. A load taken too late shows up as the old values running one more period. Compare values of zero, equal to TOP and above TOP, and a wrap value of zero, probe the edges of the output comparison and the shortest turnaround.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

  // Counting direction of the slice counter.
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } pwm_dir_e;

endpackage

// File: rtl/pwm_shadow_bank.sv
// One software-written shadow register and its working copy.
// The working copy follows the shadow only on the load strobe.
module pwm_shadow_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] work_q
);

  logic [W-1:0] shadow_q;
  logic [W-1:0] shadow_d;
  logic [W-1:0] work_d;

  always_comb begin
    shadow_d = shadow_q;
    work_d   = work_q;
    if (wr) begin
      shadow_d = wdata;
    end
    if (load) begin
      // Registered shadow: a write in the load cycle applies one period later.
      work_d = shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      work_q   <= '0;
    end else begin
      shadow_q <= shadow_d;
      work_q   <= work_d;
    end
  end

endmodule

// File: rtl/pwm_counter.sv
// Period counter with up-count and up/down phase-correct modes.
// boundary is a combinational pulse in the cycle whose edge starts a period.
module pwm_counter
  import pwm_slice_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         phase_correct,
  input  logic [W-1:0] top_w,
  output logic [W-1:0] count_q,
  output pwm_dir_e     dir_q,
  output logic         boundary
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] count_d;
  pwm_dir_e     dir_d;
  logic         at_top;
  logic         at_zero;

  assign at_top  = (count_q >= top_w);
  assign at_zero = (count_q == ZERO);

  always_comb begin
    count_d  = count_q;
    dir_d    = dir_q;
    boundary = 1'b0;
    if (tick) begin
      if (!phase_correct) begin
        dir_d = DIR_UP;
        if (at_top) begin
          count_d  = ZERO;
          boundary = 1'b1;
        end else begin
          count_d = count_q + ONE;
        end
      end else if (dir_q == DIR_UP) begin
        if (at_top) begin
          dir_d = DIR_DOWN;      // hold the top value for one count
        end else begin
          count_d = count_q + ONE;
        end
      end else begin
        if (at_zero) begin
          dir_d    = DIR_UP;     // 0 -> 0 turnaround ends the period
          boundary = 1'b1;
        end else begin
          count_d = count_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= ZERO;
      dir_q   <= DIR_UP;
    end else if (tick) begin
      count_q <= count_d;
      dir_q   <= dir_d;
    end
  end

endmodule

// File: rtl/pwm_irq_flag.sv
// Sticky interrupt flag: set by a period boundary, cleared by software.
module pwm_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);

  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) begin
      flag_d = 1'b0;
    end
    if (set) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/pwm_slice.sv
// Top of one double-buffered PWM slice.
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         cnt_en,
  input  logic         phase_correct,
  input  logic         top_wr,
  input  logic [W-1:0] top_wdata,
  input  logic         cc_wr,
  input  logic [W-1:0] cc_wdata,
  input  logic         irq_clr,
  output logic [W-1:0] count,
  output logic         pwm_out,
  output logic         irq
);

  logic         tick;
  logic         boundary;
  logic [W-1:0] top_work;
  logic [W-1:0] cc_work;
  pwm_dir_e     dir;

  assign tick = en & cnt_en;

  pwm_shadow_bank #(.W(W)) u_top_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (top_wr),
    .wdata  (top_wdata),
    .load   (boundary),
    .work_q (top_work)
  );

  pwm_shadow_bank #(.W(W)) u_cc_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cc_wr),
    .wdata  (cc_wdata),
    .load   (boundary),
    .work_q (cc_work)
  );

  pwm_counter #(.W(W)) u_counter (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .phase_correct (phase_correct),
    .top_w         (top_work),
    .count_q       (count),
    .dir_q         (dir),
    .boundary      (boundary)
  );

  pwm_irq_flag u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (boundary),
    .clr    (irq_clr),
    .flag_q (irq)
  );

  // Output: high while the count is below the working compare value.
  assign pwm_out = (count < cc_work);

endmodule

// File: rtl/pwm_slice_checker.sv
module pwm_slice_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         cnt_en,
  input logic         irq_clr,
  input logic [W-1:0] count,
  input logic         pwm_out,
  input logic         irq,
  input logic [W-1:0] top_w,
  input logic [W-1:0] cc_w
);

  // R1 / R2: the count never passes the working wrap value.
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= top_w);

  // R3: working values change only where a period starts at zero.
  a_r3_top_load_point: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(top_w) |-> (count == '0));

  a_r3_cc_load_point: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cc_w) |-> (count == '0));

  // R4: a zero compare value never drives the output high.
  a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_w == '0) |-> !pwm_out);

  // R5: the flag stays set unless cleared, and only falls after a clear.
  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  a_r5_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr));

  // R6: no count movement without a count enable.
  a_r6_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

  // R7: disabled slice keeps its output.
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pwm_out) && $stable(count)));

endmodule

bind pwm_slice pwm_slice_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .cnt_en  (cnt_en),
  .irq_clr (irq_clr),
  .count   (count),
  .pwm_out (pwm_out),
  .irq     (irq),
  .top_w   (top_work),
  .cc_w    (cc_work)
);

// File: tb/sim_pwm_slice.sv
`timescale 1ns/1ps
module sim_pwm_slice;

  localparam int W = 16;
  localparam logic [W-1:0] GT = 16'd2;
  localparam logic [W-1:0] GC = 16'd9;

  typedef struct {
    logic [W-1:0] cnt;
    logic         out;
    string        tag;
  } item_t;

  logic         clk;
  logic         rst_n;
  logic         en;
  logic         cnt_en;
  logic         phase_correct;
  logic         top_wr;
  logic [W-1:0] top_wdata;
  logic         cc_wr;
  logic [W-1:0] cc_wdata;
  logic         irq_clr;
  logic [W-1:0] count;
  logic         pwm_out;
  logic         irq;

  int    checks;
  int    errors;
  bit    mon_on;
  bit    gate_on;
  bit    cnt_en_req;
  bit    tick_q;
  bit    done;
  logic [7:0] lfsr;
  item_t q[$];

  pwm_slice #(.W(W)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .cnt_en        (cnt_en),
    .phase_correct (phase_correct),
    .top_wr        (top_wr),
    .top_wdata     (top_wdata),
    .cc_wr         (cc_wr),
    .cc_wdata      (cc_wdata),
    .irq_clr       (irq_clr),
    .count         (count),
    .pwm_out       (pwm_out),
    .irq           (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Count-enable driver: steady request or pseudo-random gating.
  initial lfsr = 8'hA5;
  always @(negedge clk) begin
    #3;
    if (gate_on) begin
      lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cnt_en <= lfsr[0] | lfsr[3];
    end else begin
      cnt_en <= cnt_en_req;
    end
  end

  // Did the last edge carry a counting cycle (from the bench's own inputs)?
  always @(posedge clk) tick_q <= (en === 1'b1) && (cnt_en === 1'b1);

  // Monitor: one expected item per counting cycle.
  always @(negedge clk) begin
    if (mon_on && tick_q && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (count !== e.cnt || pwm_out !== e.out) begin
        errors++;
        $display("FAIL %s count=%0d exp %0d out=%b exp %b", e.tag, count, e.cnt, pwm_out, e.out);
      end
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_period(input logic [W-1:0] t, input logic [W-1:0] c, input bit pc);
    string tg;
    tg = pc ? "R2/R3/R4" : "R1/R3/R4";
    for (int i = 0; i <= int'(t); i++) q.push_back('{cnt: W'(i), out: (W'(i) < c), tag: tg});
    if (pc) begin
      for (int i = int'(t); i >= 0; i--) q.push_back('{cnt: W'(i), out: (W'(i) < c), tag: tg});
    end
  endtask

  task automatic write_shadow(input logic [W-1:0] t, input logic [W-1:0] c);
    top_wdata = t;
    cc_wdata  = c;
    top_wr    = 1'b1;
    cc_wr     = 1'b1;
    @(posedge clk);
    #1;
    top_wr = 1'b0;
    cc_wr  = 1'b0;
  endtask

  task automatic wait_size(input int n);
    @(negedge clk);
    #2;
    while (q.size() > n) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic do_period(input logic [W-1:0] t, input logic [W-1:0] c, input bit pc, input bit garble);
    if (garble) begin
      wait_size(2);
      write_shadow(GT, GC);   // R3: overwritten before the boundary
    end
    wait_size(1);
    write_shadow(t, c);
    push_period(t, c, pc);
  endtask

  task automatic do_reset(input bit pc);
    rst_n         = 1'b0;
    en            = 1'b0;
    cnt_en_req    = 1'b1;
    gate_on       = 1'b0;
    mon_on        = 1'b0;
    top_wr        = 1'b0;
    cc_wr         = 1'b0;
    top_wdata     = '0;
    cc_wdata      = '0;
    irq_clr       = 1'b0;
    phase_correct = pc;
    repeat (3) @(negedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 count", count, '0);
    check("R8 pwm_out", W'(pwm_out), '0);
    check("R8 irq", W'(irq), '0);
  endtask

  task automatic prime(input logic [W-1:0] t, input logic [W-1:0] c, input bit pc);
    write_shadow(t, c);
    push_period(t, c, pc);
    en = 1'b1;
    do begin
      @(posedge clk);
      #1;
    end while (irq !== 1'b1);
    mon_on = 1'b1;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    #2;
    mon_on = 1'b0;
  endtask

  initial begin
    logic [W-1:0] c0;
    logic         o0;
    int           n;
    checks = 0;
    errors = 0;
    done   = 1'b0;

    // Up-count mode, continuous counting.
    do_reset(1'b0);
    prime(16'd4, 16'd2, 1'b0);
    do_period(16'd6, 16'd0, 1'b0, 1'b1);   // R4 compare of zero
    do_period(16'd3, 16'd9, 1'b0, 1'b1);   // R4 compare above TOP
    do_period(16'd5, 16'd5, 1'b0, 1'b1);   // R4 compare equal to TOP
    do_period(16'd2, 16'd1, 1'b0, 1'b1);
    do_period(16'd4, 16'd3, 1'b0, 1'b0);
    drain();

    // Phase-correct mode, randomly gated counting (R6).
    do_reset(1'b1);
    prime(16'd3, 16'd2, 1'b1);
    gate_on = 1'b1;
    do_period(16'd2, 16'd1, 1'b1, 1'b0);
    do_period(16'd0, 16'd1, 1'b1, 1'b0);   // R2 shortest turnaround
    do_period(16'd4, 16'd0, 1'b1, 1'b0);
    do_period(16'd3, 16'd3, 1'b1, 1'b1);
    do_period(16'd1, 16'd2, 1'b1, 1'b0);
    drain();
    gate_on    = 1'b0;
    cnt_en_req = 1'b1;

    // Directed checks: freeze, clear, gating, sticky flag.
    en = 1'b0;
    repeat (2) @(negedge clk);
    c0 = count;
    o0 = pwm_out;
    check("R5 sticky over periods", W'(irq), W'(1));
    #2;
    irq_clr = 1'b1;
    @(posedge clk);
    #1;
    irq_clr = 1'b0;
    @(negedge clk);
    check("R5 cleared", W'(irq), '0);
    #2;
    write_shadow(16'd1, 16'd0);
    repeat (4) @(negedge clk);
    check("R7 count frozen", count, c0);
    check("R7 output frozen", W'(pwm_out), W'(o0));
    check("R7 no boundary while frozen", W'(irq), '0);
    #2;
    cnt_en_req = 1'b0;
    @(negedge clk);
    #5;
    en = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 count held without cnt_en", count, c0);
    check("R6 irq held without cnt_en", W'(irq), '0);
    cnt_en_req = 1'b1;
    n = 0;
    while (irq !== 1'b1 && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R5 set at boundary", W'(irq), W'(1));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R5 stays set", W'(irq), W'(1));
      check("R4 new compare of zero keeps output low", W'(pwm_out), '0);
      check("R3 new wrap value applied", W'(count <= 16'd1), W'(1));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule